// File: doc/BRIEF.md
# Presence-Tagged Handoff Memory

This block is a small register-based memory in which every word carries a single presence flag. The flag shows whether the word holds a value that no consumer has taken yet. A producer hands a value to a consumer one word at a time. The producer issues a guarded store, which succeeds only while the slot is vacant. The consumer issues a guarded load, which succeeds only while the slot is occupied. Each successful guarded access tests the flag, moves the data and flips the flag in the same clock edge, so no other access can see a half-finished state. A guarded access that finds the flag in the wrong state is refused with a retry response and leaves the slot untouched. The requester is expected to try again later.

A third, unguarded port reads and writes data without looking at the flags. It is used for setup and debugging. A synchronous clear input marks every slot vacant in one cycle.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every slot is vacant, and all acknowledge and retry outputs are low until a request arrives.
- R2: A guarded store to a vacant slot writes the data, marks the slot occupied and raises `st_ack` one cycle after the request.
- R3: A guarded store to an occupied slot raises `st_retry` one cycle later and changes neither the data nor the flag.
- R4: A guarded load from an occupied slot returns the stored word on `ld_data`, raises `ld_ack` one cycle later and marks the slot vacant.
- R5: A guarded load from a vacant slot raises `ld_retry` one cycle later and changes neither the data nor the flag.
- R6: An unguarded write changes the word but never the flag.
- R7: An unguarded read returns the word on `raw_rdata` one cycle later and never changes the flag.
- R8: When a guarded load and a guarded store target the same slot in one cycle, the load is judged on the flag as it stood before that cycle. The store is judged after the load. On a vacant slot the load is refused and the store succeeds. On an occupied slot the load takes the old word and the store succeeds with the new one, so the slot ends up occupied.
- R9: A cycle with `clr_tags` high marks every slot vacant and refuses every guarded request made in that cycle with a retry.
- R10: When a guarded store succeeds and an unguarded write targets the same word in the same cycle, the guarded store's data is kept.
- R11: A guarded request receives exactly one of acknowledge or retry, in the cycle after it is presented. A cycle without a request raises neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_tags | input | 1 | Synchronous clear of all presence flags |
| st_req | input | 1 | Guarded store request |
| st_addr | input | AW | Guarded store word address |
| st_data | input | WIDTH | Guarded store data |
| st_ack | output | 1 | Guarded store completed |
| st_retry | output | 1 | Guarded store refused, slot occupied |
| ld_req | input | 1 | Guarded load request |
| ld_addr | input | AW | Guarded load word address |
| ld_data | output | WIDTH | Guarded load data, valid with ld_ack |
| ld_ack | output | 1 | Guarded load completed |
| ld_retry | output | 1 | Guarded load refused, slot vacant |
| raw_we | input | 1 | Unguarded write enable |
| raw_re | input | 1 | Unguarded read enable |
| raw_addr | input | AW | Unguarded word address |
| raw_wdata | input | WIDTH | Unguarded write data |
| raw_rdata | output | WIDTH | Unguarded read data |

## Verification
Every response arrives on the clock edge that samples its request. Acknowledge, retry, load data and raw read data are all due one cycle after the request is presented, and memory state changes at that same edge. The bench drives each request on a falling edge. It computes the expected responses from its own copy of the flags and data as they stood before the rising edge, and compares shortly after that edge. It updates its copy only after comparing, so the same-slot load and store ordering is predicted from the state before the cycle.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;
  typedef struct packed {
    logic ack;
    logic retry;
  } fe_rsp_t;
endpackage

// File: rtl/fe_access_ctrl.sv
module fe_access_ctrl
  import fe_mem_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clr_tags,
  input  logic             st_req,
  input  logic [AW-1:0]    st_addr,
  input  logic             ld_req,
  input  logic [AW-1:0]    ld_addr,
  input  logic [DEPTH-1:0] tag_q,
  output logic             st_grant,
  output logic             ld_grant,
  output fe_rsp_t          st_rsp,
  output fe_rsp_t          ld_rsp
);
  logic same_slot;

  always_comb begin
    same_slot = (st_addr == ld_addr);
    // the load sees the flag as it stood before the cycle
    ld_grant  = ld_req && !clr_tags && tag_q[ld_addr];
    // the store is judged after the load has been applied
    st_grant  = st_req && !clr_tags &&
                (!tag_q[st_addr] || (ld_grant && same_slot));
    st_rsp.ack   = st_grant;
    st_rsp.retry = st_req && !st_grant;
    ld_rsp.ack   = ld_grant;
    ld_rsp.retry = ld_req && !ld_grant;
  end
endmodule

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_tags,
  input  logic             set_en,
  input  logic [AW-1:0]    set_addr,
  input  logic             clr_en,
  input  logic [AW-1:0]    clr_addr,
  output logic [DEPTH-1:0] tag_q
);
  logic [DEPTH-1:0] tag_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      tag_d[i] = tag_q[i];
      if (clr_tags) begin
        tag_d[i] = 1'b0;
      end else if (set_en && (set_addr == AW'(i))) begin
        tag_d[i] = 1'b1;
      end else if (clr_en && (clr_addr == AW'(i))) begin
        tag_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else begin
      tag_q <= tag_d;
    end
  end

  // R9
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_tags) |-> (tag_q == '0));
  // R2
  store_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_en && !clr_tags) |-> tag_q[$past(set_addr)]);
  // R4
  load_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_en && !clr_tags && !(set_en && set_addr == clr_addr))
      |-> !tag_q[$past(clr_addr)]);
endmodule

// File: rtl/fe_data_array.sv
module fe_data_array #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_we,
  input  logic [AW-1:0]    sync_addr,
  input  logic [WIDTH-1:0] sync_wdata,
  input  logic             plain_we,
  input  logic [AW-1:0]    plain_addr,
  input  logic [WIDTH-1:0] plain_wdata,
  input  logic             sync_re,
  input  logic [AW-1:0]    sync_raddr,
  output logic [WIDTH-1:0] sync_rdata,
  input  logic             plain_re,
  output logic [WIDTH-1:0] plain_rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] mem_d [DEPTH];
  logic [DEPTH-1:0] word_en;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_comb begin
      word_en[i] = 1'b0;
      mem_d[i]   = mem_q[i];
      if (sync_we && (sync_addr == AW'(i))) begin
        word_en[i] = 1'b1;
        mem_d[i]   = sync_wdata;
      end else if (plain_we && (plain_addr == AW'(i))) begin
        word_en[i] = 1'b1;
        mem_d[i]   = plain_wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (word_en[i]) begin
        mem_q[i] <= mem_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_rdata  <= '0;
      plain_rdata <= '0;
    end else begin
      if (sync_re) begin
        sync_rdata <= mem_q[sync_raddr];
      end
      if (plain_re) begin
        plain_rdata <= mem_q[plain_addr];
      end
    end
  end

  // R10
  sync_beats_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_we && plain_we && (sync_addr == plain_addr))
      |-> (mem_q[$past(sync_addr)] == $past(sync_wdata)));
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
  import fe_mem_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_tags,
  input  logic             st_req,
  input  logic [AW-1:0]    st_addr,
  input  logic [WIDTH-1:0] st_data,
  output logic             st_ack,
  output logic             st_retry,
  input  logic             ld_req,
  input  logic [AW-1:0]    ld_addr,
  output logic [WIDTH-1:0] ld_data,
  output logic             ld_ack,
  output logic             ld_retry,
  input  logic             raw_we,
  input  logic             raw_re,
  input  logic [AW-1:0]    raw_addr,
  input  logic [WIDTH-1:0] raw_wdata,
  output logic [WIDTH-1:0] raw_rdata
);
  logic [DEPTH-1:0] tag_q;
  logic             st_grant;
  logic             ld_grant;
  fe_rsp_t          st_rsp_d, ld_rsp_d, st_rsp_q, ld_rsp_q;

  fe_access_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clr_tags (clr_tags),
    .st_req   (st_req),
    .st_addr  (st_addr),
    .ld_req   (ld_req),
    .ld_addr  (ld_addr),
    .tag_q    (tag_q),
    .st_grant (st_grant),
    .ld_grant (ld_grant),
    .st_rsp   (st_rsp_d),
    .ld_rsp   (ld_rsp_d)
  );

  fe_tag_array #(.DEPTH(DEPTH)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_tags (clr_tags),
    .set_en   (st_grant),
    .set_addr (st_addr),
    .clr_en   (ld_grant),
    .clr_addr (ld_addr),
    .tag_q    (tag_q)
  );

  fe_data_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_we     (st_grant),
    .sync_addr   (st_addr),
    .sync_wdata  (st_data),
    .plain_we    (raw_we),
    .plain_addr  (raw_addr),
    .plain_wdata (raw_wdata),
    .sync_re     (ld_grant),
    .sync_raddr  (ld_addr),
    .sync_rdata  (ld_data),
    .plain_re    (raw_re),
    .plain_rdata (raw_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_rsp_q <= '0;
      ld_rsp_q <= '0;
    end else begin
      st_rsp_q <= st_rsp_d;
      ld_rsp_q <= ld_rsp_d;
    end
  end

  assign st_ack   = st_rsp_q.ack;
  assign st_retry = st_rsp_q.retry;
  assign ld_ack   = ld_rsp_q.ack;
  assign ld_retry = ld_rsp_q.retry;

  // R11
  store_one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_req) |-> (st_ack != st_retry));
  // R11
  load_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_req) |-> (!ld_ack && !ld_retry));
  // R5
  refused_load_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_req && !tag_q[ld_addr] && !(st_req && st_addr == ld_addr))
      |-> !tag_q[$past(ld_addr)]);
endmodule

// File: tb/fe_sync_mem_test.sv
`timescale 1ns/1ps
module fe_sync_mem_test;
  localparam int DEPTH = 16;
  localparam int WIDTH = 16;
  localparam int AW = 4;

  logic clk, rst_n, clr_tags;
  logic st_req, ld_req, raw_we, raw_re;
  logic [AW-1:0] st_addr, ld_addr, raw_addr;
  logic [WIDTH-1:0] st_data, raw_wdata, ld_data, raw_rdata;
  logic st_ack, st_retry, ld_ack, ld_retry;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [WIDTH-1:0] mdat [DEPTH];
  logic mtag [DEPTH];

  fe_sync_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 200000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit pr, input logic [AW-1:0] pa, input logic [WIDTH-1:0] pd,
                      input bit cr, input logic [AW-1:0] ca,
                      input bit xw, input bit xr, input logic [AW-1:0] xa,
                      input logic [WIDTH-1:0] xd, input bit cl, input string tag);
    bit rok, wok;
    logic [WIDTH-1:0] exp_c, exp_x;
    string lp, lc;
    @(negedge clk);
    st_req = pr; st_addr = pa; st_data = pd;
    ld_req = cr; ld_addr = ca;
    raw_we = xw; raw_re = xr; raw_addr = xa; raw_wdata = xd;
    clr_tags = cl;
    rok = cr && !cl && mtag[ca];
    wok = pr && !cl && (!mtag[pa] || (rok && ca == pa));
    exp_c = mdat[ca];
    exp_x = mdat[xa];
    if (tag != "") begin
      lp = tag;
      lc = tag;
    end else begin
      lp = cl ? "R9" : (rok && ca == pa) ? "R8" : wok ? "R2" : "R3";
      lc = cl ? "R9" : rok ? "R4" : "R5";
    end
    @(posedge clk);
    #1;
    chk(st_ack == wok, {lp, " R11 st_ack"}, 32'(st_ack), 32'(wok));
    chk(st_retry == (pr && !wok), {lp, " R11 st_retry"}, 32'(st_retry), 32'(pr && !wok));
    chk(ld_ack == rok, {lc, " R11 ld_ack"}, 32'(ld_ack), 32'(rok));
    chk(ld_retry == (cr && !rok), {lc, " R11 ld_retry"}, 32'(ld_retry), 32'(cr && !rok));
    if (rok) chk(ld_data == exp_c, {lc, " ld_data"}, 32'(ld_data), 32'(exp_c));
    if (xr) chk(raw_rdata == exp_x, "R7 raw_rdata", 32'(raw_rdata), 32'(exp_x));
    if (cl) begin
      for (int i = 0; i < DEPTH; i++) mtag[i] = 1'b0;
    end else begin
      if (rok) mtag[ca] = 1'b0;
      if (wok) mtag[pa] = 1'b1;
    end
    if (xw) mdat[xa] = xd;
    if (wok) mdat[pa] = pd;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; clr_tags = 1'b0;
    st_req = 1'b0; ld_req = 1'b0; raw_we = 1'b0; raw_re = 1'b0;
    st_addr = '0; ld_addr = '0; raw_addr = '0; st_data = '0; raw_wdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      mtag[i] = 1'b0;
      mdat[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(!st_ack && !st_retry && !ld_ack && !ld_retry, "R1 outputs in reset",
        {st_ack, st_retry, ld_ack, ld_retry}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: every slot vacant after reset, outputs quiet with no request
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, AW'(i), 0, 0, 0, 0, 0, "R1");
    // R6: fill via unguarded port, flags stay vacant
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, 0, 0, 0, 1, 0, AW'(i), WIDTH'(16'h1000 + i), 0, "R6");
    step(0, 0, 0, 1, 3, 0, 1, 3, 0, 0, "R6");
    // R2 / R3 / R7 / R4 / R5 on slot 3
    step(1, 3, 16'hA5A5, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 3, 16'h5A5A, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 1, 3, 0, 0, "R7");
    step(0, 0, 0, 1, 3, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 3, 0, 1, 3, 0, 0, "R5");
    // R6: unguarded write on an occupied slot keeps it occupied
    step(1, 4, 16'h4444, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 0, 4, 16'h4A4A, 0, "R6");
    step(0, 0, 0, 1, 4, 0, 0, 0, 0, 0, "R6");
    // R8: same slot, vacant then occupied
    step(1, 5, 16'h0055, 1, 5, 0, 0, 0, 0, 0, "R8");
    step(1, 5, 16'h5500, 1, 5, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 5, 0, 0, 0, 0, 0, "R8");
    // R10: guarded and unguarded write to slot 7 together
    step(1, 7, 16'h7777, 0, 0, 1, 0, 7, 16'hDEAD, 0, "R10");
    step(0, 0, 0, 1, 7, 0, 0, 0, 0, 0, "R10");
    // R9: occupy slots, then clear with requests pending
    for (int i = 8; i < 12; i++) step(1, AW'(i), WIDTH'(i), 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 2, 16'h2222, 1, 8, 0, 0, 0, 0, 1, "R9");
    for (int i = 8; i < 12; i++) step(0, 0, 0, 1, AW'(i), 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 1, 2, 0, 0, 0, 0, 0, "R9");
    // random mix, narrow address range for frequent collisions
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] m;
      m = (n % 2 == 0) ? AW'(3) : AW'(15);
      step($urandom % 2, AW'($urandom) & m, WIDTH'($urandom),
           $urandom % 2, AW'($urandom) & m,
           ($urandom % 4) == 0, $urandom % 2, AW'($urandom) & m, WIDTH'($urandom),
           ($urandom % 50) == 0, "");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule